// File: doc/BRIEF.md
# Four-Channel Event-Triggered DMA Controller

The block copies blocks of memory on behalf of a processor. It has four channels. Each channel holds a 32-bit source address, a 32-bit destination address, a 16-bit unit count and a 16-bit control word. Software loads these through a 16-bit register write port, and it can read every register back through a combinational read port.

A channel becomes ready in one of two ways. It can be ready as soon as its control word is written with the enable bit set. It can also wait for a vertical-blank or horizontal-blank pulse. Ready channels join a first-in first-out queue, and the engine serves them one at a time over a simple synchronous memory master port. Each unit moved is one read from the source followed by one write to the destination. The addresses then step according to each channel's own adjust rule.

While anything is queued or a block is moving, the block raises a stall output that holds the processor off the bus. At the end of a block a channel can pulse its own interrupt line. A channel can also stay armed for the next trigger and restore its destination address.

Top module: `evdma_top`

## Requirements
- R1: After reset every channel register reads as zero, the memory port is idle, cpuStall is low and no interrupt line is high.
- R2: The registers of channel n sit at byte offset 12*n plus a sub-offset: 0 source bits 15:0, 2 source bits 31:16, 4 destination bits 15:0, 6 destination bits 31:16, 8 unit count, 10 control. Writing one half of an address leaves the other half unchanged.
- R3: The control word fields are: bits 6:5 destination adjust, bits 8:7 source adjust, bit 9 repeat, bit 10 unit size (1 = 32-bit, 0 = 16-bit), bits 13:12 start timing, bit 14 interrupt at end, and bit 15 enable.
- R4: Writing control with bit 15 set and start timing 0 queues that channel at once. Timing 1 or 2 written this way starts no transfer.
- R5: A vblankPulse queues every enabled channel whose timing is 1, and an hblankPulse queues every enabled channel whose timing is 2. Channels triggered in the same cycle are queued in ascending channel order. Channels with any other timing are not affected.
- R6: A unit is a memRd at the source address with memWord equal to the size bit. The read data is taken in the cycle memAck is high, and memWr to the destination follows in the next cycle with that data. A dequeued channel moves exactly as many units as its count, so a count of 0 moves none.
- R7: After each unit, each address moves by the unit size (2 or 4 bytes). Adjust code 0 increments, 1 decrements and 2 holds. Destination code 3 also increments.
- R8: A source adjust code of 3 leaves the source address unchanged and pulses srcAdjErr in the cycle of that unit's write.
- R9: At the end of a block whose control bit 14 is set, channel n pulses irq[n] for one cycle. Without bit 14 it gives no pulse.
- R10: When a block ends with the repeat bit set, the channel stays enabled, and destination code 3 restores the destination to its value at block start. With repeat clear, the enable bit reads back as 0 and the other control bits are kept.
- R11: Queued channels are served one after another in trigger order. cpuStall is high whenever a channel is queued or a block is moving, and it drops once both are done.
- R12: A channel that is queued or moving is not queued again by a further trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset, for both write and read |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr |
| vblankPulse | input | 1 | Vertical-blank trigger pulse |
| hblankPulse | input | 1 | Horizontal-blank trigger pulse |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memWord | output | 1 | Access size: 1 word, 0 halfword |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Read data valid |
| irq | output | 4 | Per-channel end-of-block interrupt pulses |
| cpuStall | output | 1 | Holds the processor while transfers are pending |
| srcAdjErr | output | 1 | Illegal source adjust code used |

## Verification
Blocks are run with incrementing halfword copies, decrementing word copies into a fixed destination, an illegal source adjust code, and a zero count. Comparing the address streams tells the step size, the direction and the hold rules apart, and the zero count isolates the end-of-block handling. Blank pulses are sent with channels armed for each timing value, including two channels triggered together, to separate timing selection from queue order. Back-to-back immediate starts, a repeating channel with destination reload, and a second trigger while a channel is still pending test the FIFO order, the reload path and duplicate suppression.

// File: rtl/evdma_pkg.sv
package evdma_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int STRIDE = 12;
  localparam int REG_AW = $clog2(NUM_CH * STRIDE);

  // control word bit positions (decoded by software, so fixed)
  localparam int B_DADJ = 5;
  localparam int B_SADJ = 7;
  localparam int B_RPT  = 9;
  localparam int B_WORD = 10;
  localparam int B_TIM  = 12;
  localparam int B_IRQ  = 14;
  localparam int B_EN   = 15;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            capture;
    logic            latch;
    logic            step;
    logic            finish;
  } strobe_t;
endpackage

// File: rtl/evdma_path.sv
module evdma_path
  import evdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WC_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcCur,
  output logic [ADDR_W-1:0] dstCur,
  output logic [DATA_W-1:0] memWdata,
  output logic [WC_W-1:0]   wcCur,
  output logic              wordCur,
  output logic              irqEnCur,
  output logic              srcAdjErr,
  output logic [NUM_CH-1:0] immVec,
  output logic [NUM_CH-1:0] vbVec,
  output logic [NUM_CH-1:0] hbVec
);
  logic [ADDR_W-1:0] srcR [NUM_CH];
  logic [ADDR_W-1:0] dstR [NUM_CH];
  logic [WC_W-1:0]   wcR  [NUM_CH];
  logic [15:0]       ctlR [NUM_CH];
  logic [ADDR_W-1:0] dstRld;
  logic [DATA_W-1:0] dataR;

  logic            selHit, wrEn;
  logic [CH_W-1:0] selChan;
  logic [3:0]      selSub;

  function automatic logic [ADDR_W-1:0] adjAddr(input logic [ADDR_W-1:0] a,
      input logic [1:0] code, input logic word, input logic isDst);
    logic [ADDR_W-1:0] unit;
    unit = word ? ADDR_W'(4) : ADDR_W'(2);
    case (code)
      2'd0:    return a + unit;
      2'd1:    return a - unit;
      2'd2:    return a;
      default: return isDst ? a + unit : a;
    endcase
  endfunction

  always_comb begin
    selHit = 1'b0; selChan = '0; selSub = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(regAddr) >= i * STRIDE && int'(regAddr) < (i + 1) * STRIDE) begin
        selHit  = 1'b1;
        selChan = CH_W'(i);
        selSub  = 4'(int'(regAddr) - i * STRIDE);
      end
    end
  end
  assign wrEn = regWe && selHit;

  always_comb begin
    regRdata = '0;
    if (selHit) begin
      case (selSub)
        4'd0:  regRdata = srcR[selChan][15:0];
        4'd2:  regRdata = srcR[selChan][ADDR_W-1:16];
        4'd4:  regRdata = dstR[selChan][15:0];
        4'd6:  regRdata = dstR[selChan][ADDR_W-1:16];
        4'd8:  regRdata = wcR[selChan];
        4'd10: regRdata = ctlR[selChan];
        default: regRdata = '0;
      endcase
    end
  end

  always_comb begin
    immVec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      vbVec[i] = ctlR[i][B_EN] && ctlR[i][B_TIM+:2] == 2'd1;
      hbVec[i] = ctlR[i][B_EN] && ctlR[i][B_TIM+:2] == 2'd2;
    end
    if (wrEn && selSub == 4'd10 && regWdata[B_EN] && regWdata[B_TIM+:2] == 2'd0)
      immVec[selChan] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        srcR[i] <= '0; dstR[i] <= '0; wcR[i] <= '0; ctlR[i] <= '0;
      end
      dstRld <= '0;
      dataR  <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrEn && selChan == CH_W'(i)) begin
          case (selSub)
            4'd0:  srcR[i][15:0]        <= regWdata;
            4'd2:  srcR[i][ADDR_W-1:16] <= regWdata[ADDR_W-17:0];
            4'd4:  dstR[i][15:0]        <= regWdata;
            4'd6:  dstR[i][ADDR_W-1:16] <= regWdata[ADDR_W-17:0];
            4'd8:  wcR[i]               <= WC_W'(regWdata);
            4'd10: ctlR[i]              <= regWdata;
            default: ;
          endcase
        end
        if (strb.step && strb.chan == CH_W'(i)) begin
          srcR[i] <= adjAddr(srcR[i], ctlR[i][B_SADJ+:2], ctlR[i][B_WORD], 1'b0);
          dstR[i] <= adjAddr(dstR[i], ctlR[i][B_DADJ+:2], ctlR[i][B_WORD], 1'b1);
        end
        if (strb.finish && strb.chan == CH_W'(i)) begin
          if (ctlR[i][B_RPT]) begin
            if (ctlR[i][B_DADJ+:2] == 2'd3) dstR[i] <= dstRld;
          end else begin
            ctlR[i][B_EN] <= 1'b0;
          end
        end
      end
      if (strb.capture) dstRld <= dstR[strb.chan];
      if (strb.latch)   dataR  <= memRdata;
    end
  end

  assign srcCur    = srcR[strb.chan];
  assign dstCur    = dstR[strb.chan];
  assign wcCur     = wcR[strb.chan];
  assign wordCur   = ctlR[strb.chan][B_WORD];
  assign irqEnCur  = ctlR[strb.chan][B_IRQ];
  assign memWdata  = dataR;
  assign srcAdjErr = strb.step && ctlR[strb.chan][B_SADJ+:2] == 2'd3;

  // R8: an illegal source code leaves the source address where it was
  a_r8_src_held: assert property (@(posedge clk) disable iff (!rstN)
    srcAdjErr |=> srcCur == $past(srcCur));
  // R10: a block without repeat leaves its channel disabled
  a_r10_enable_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !ctlR[strb.chan][B_RPT] && !regWe) |=> !ctlR[strb.chan][B_EN]);
  // R2: a high-half source write keeps the low half
  a_r2_half_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selSub == 4'd2 && !strb.step) |=>
      srcR[$past(selChan)][15:0] == $past(srcR[selChan][15:0]));
endmodule

// File: rtl/evdma_seq.sv
module evdma_seq
  import evdma_pkg::*;
#(
  parameter int WC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] immVec,
  input  logic [NUM_CH-1:0] vbVec,
  input  logic [NUM_CH-1:0] hbVec,
  input  logic              vblankPulse,
  input  logic              hblankPulse,
  input  logic              memAck,
  input  logic [WC_W-1:0]   wcCur,
  input  logic              irqEnCur,
  output strobe_t           strb,
  output logic              memRd,
  output logic              memWr,
  output logic [NUM_CH-1:0] irq,
  output logic              cpuStall
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_WT, S_WR, S_DONE} state_e;

  state_e            state;
  logic [CH_W-1:0]   chanR;
  logic [WC_W-1:0]   cnt;
  logic [CH_W-1:0]   qSlot [NUM_CH];
  logic [CH_W-1:0]   qNext [NUM_CH];
  logic [CH_W:0]     qCnt, cntNext;
  logic [NUM_CH-1:0] pend, pendNext, reqVec;
  logic              pop;

  assign reqVec = immVec | (vblankPulse ? vbVec : '0) | (hblankPulse ? hbVec : '0);
  assign pop    = state == S_IDLE && qCnt != '0;

  always_comb begin
    qNext   = qSlot;
    cntNext = qCnt;
    pendNext = pend;
    if (state == S_DONE) pendNext[chanR] = 1'b0;
    if (pop) begin
      for (int i = 0; i < NUM_CH - 1; i++) qNext[i] = qSlot[i + 1];
      cntNext = qCnt - (CH_W + 1)'(1);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (reqVec[i] && !pend[i] && cntNext < (CH_W + 1)'(NUM_CH)) begin
        qNext[cntNext[CH_W-1:0]] = CH_W'(i);
        cntNext     = cntNext + (CH_W + 1)'(1);
        pendNext[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; chanR <= '0; cnt <= '0; qCnt <= '0; pend <= '0;
      for (int i = 0; i < NUM_CH; i++) qSlot[i] <= '0;
    end else begin
      qSlot <= qNext;
      qCnt  <= cntNext;
      pend  <= pendNext;
      case (state)
        S_IDLE: if (pop) begin chanR <= qSlot[0]; state <= S_LOAD; end
        S_LOAD: begin cnt <= wcCur; state <= (wcCur == '0) ? S_DONE : S_RD; end
        S_RD:   state <= S_WT;
        S_WT:   if (memAck) state <= S_WR;
        S_WR:   begin
          cnt   <= cnt - WC_W'(1);
          state <= (cnt == WC_W'(1)) ? S_DONE : S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.chan    = chanR;
    strb.capture = state == S_LOAD;
    strb.latch   = state == S_WT && memAck;
    strb.step    = state == S_WR;
    strb.finish  = state == S_DONE;
    irq          = '0;
    if (state == S_DONE && irqEnCur) irq[chanR] = 1'b1;
  end
  assign memRd    = state == S_RD;
  assign memWr    = state == S_WR;
  assign cpuStall = state != S_IDLE || qCnt != '0;

  // R6: a write is always preceded by an acknowledged read
  a_r6_write_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memAck));
  a_r6_rd_wr_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R9: at most one channel interrupts at a time
  a_r9_irq_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irq));
  // R11: bus activity only while the processor is held
  a_r11_stall_covers_bus: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> cpuStall);
  // R12: queue never holds more than one entry per channel
  a_r12_queue_bound: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pend) >= int'(qCnt));
endmodule

// File: rtl/evdma_top.sv
module evdma_top
  import evdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [5:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        vblankPulse,
  input  logic        hblankPulse,
  output logic        memRd,
  output logic        memWr,
  output logic        memWord,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic [3:0]  irq,
  output logic        cpuStall,
  output logic        srcAdjErr
);
  strobe_t           strb;
  logic [31:0]       srcCur, dstCur;
  logic [15:0]       wcCur;
  logic              irqEnCur;
  logic [NUM_CH-1:0] immVec, vbVec, hbVec;

  evdma_path #(.ADDR_W(32), .DATA_W(32), .WC_W(16)) uPath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb),
    .memRdata(memRdata), .srcCur(srcCur), .dstCur(dstCur),
    .memWdata(memWdata), .wcCur(wcCur), .wordCur(memWord),
    .irqEnCur(irqEnCur), .srcAdjErr(srcAdjErr),
    .immVec(immVec), .vbVec(vbVec), .hbVec(hbVec));

  evdma_seq #(.WC_W(16)) uSeq (
    .clk(clk), .rstN(rstN), .immVec(immVec), .vbVec(vbVec), .hbVec(hbVec),
    .vblankPulse(vblankPulse), .hblankPulse(hblankPulse), .memAck(memAck),
    .wcCur(wcCur), .irqEnCur(irqEnCur), .strb(strb), .memRd(memRd),
    .memWr(memWr), .irq(irq), .cpuStall(cpuStall));

  assign memAddr = memWr ? dstCur : srcCur;
endmodule

// File: tb/sim_evdma_top.sv
module sim_evdma_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0; logic [5:0] regAddr = '0; logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic vblankPulse = 1'b0, hblankPulse = 1'b0;
  logic memRd, memWr, memWord, memAck = 1'b0, cpuStall, srcAdjErr;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic [3:0] irq;

  evdma_top u0 (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 0;

  typedef struct { int kind; int unsigned addr; int unsigned data; bit word; bit err; int mask; } ev_t;
  ev_t evq[$];
  int unsigned mSrc[4], mDst[4], mWc[4], mCtl[4];
  bit pend[4];

  function automatic int unsigned memf(int unsigned a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  task automatic chk(bit ok, string msg);
    nChecks++;
    if (!ok) begin nFails++; $display("FAIL %s", msg); end
  endtask

  function automatic int unsigned step_addr(int unsigned a, int code, int unit, bit isDst);
    case (code)
      0: return a + unit;
      1: return a - unit;
      2: return a;
      default: return isDst ? a + unit : a;
    endcase
  endfunction

  // behavioural model: run a whole block when the channel is queued
  function automatic void model_queue(int ch);
    int unsigned rld; int unit; int sadj, dadj; bit word; ev_t e;
    if (pend[ch]) return;
    pend[ch] = 1;
    word = mCtl[ch][10]; unit = word ? 4 : 2;
    sadj = int'(mCtl[ch][8:7]); dadj = int'(mCtl[ch][6:5]);
    rld = mDst[ch];
    for (int k = 0; k < int'(mWc[ch]); k++) begin
      e = '{0, mSrc[ch], 0, word, 0, 0}; evq.push_back(e);
      e = '{1, mDst[ch], memf(mSrc[ch]), word, (sadj == 3), 0}; evq.push_back(e);
      mSrc[ch] = step_addr(mSrc[ch], sadj, unit, 0);
      mDst[ch] = step_addr(mDst[ch], dadj, unit, 1);
    end
    if (mCtl[ch][14]) begin e = '{2, 0, 0, 0, 0, 1 << ch}; evq.push_back(e); end
    if (mCtl[ch][9]) begin if (dadj == 3) mDst[ch] = rld; end
    else mCtl[ch][15] = 1'b0;
  endfunction

  function automatic int unsigned mread(int ch, int sub);
    case (sub)
      0: return mSrc[ch] & 32'hFFFF;   2: return mSrc[ch] >> 16;
      4: return mDst[ch] & 32'hFFFF;   6: return mDst[ch] >> 16;
      8: return mWc[ch];               10: return mCtl[ch];
      default: return 0;
    endcase
  endfunction

  task automatic reg_wr(int ch, int sub, int unsigned d);
    @(negedge clk);
    regWe = 1; regAddr = 6'(ch * 12 + sub); regWdata = 16'(d);
    case (sub)
      0: mSrc[ch] = (mSrc[ch] & 32'hFFFF0000) | (d & 32'hFFFF);
      2: mSrc[ch] = (mSrc[ch] & 32'hFFFF) | ((d & 32'hFFFF) << 16);
      4: mDst[ch] = (mDst[ch] & 32'hFFFF0000) | (d & 32'hFFFF);
      6: mDst[ch] = (mDst[ch] & 32'hFFFF) | ((d & 32'hFFFF) << 16);
      8: mWc[ch] = d & 32'hFFFF;
      10: begin
        mCtl[ch] = d & 32'hFFFF;
        if (d[15] && d[13:12] == 2'd0) model_queue(ch);
      end
      default: ;
    endcase
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic setup(int ch, int unsigned s, int unsigned dd, int w);
    reg_wr(ch, 0, s & 32'hFFFF); reg_wr(ch, 2, s >> 16);
    reg_wr(ch, 4, dd & 32'hFFFF); reg_wr(ch, 6, dd >> 16);
    reg_wr(ch, 8, w);
  endtask

  task automatic blank(bit vb);
    @(negedge clk);
    if (vb) vblankPulse = 1; else hblankPulse = 1;
    for (int i = 0; i < 4; i++)
      if (mCtl[i][15] && int'(mCtl[i][13:12]) == (vb ? 1 : 2)) model_queue(i);
    @(negedge clk);
    vblankPulse = 0; hblankPulse = 0;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    @(negedge clk);
    while ((evq.size() != 0 || cpuStall) && n < 3000) begin @(negedge clk); n++; end
    chk(evq.size() == 0 && !cpuStall,
        $sformatf("%s R11 idle: pending=%0d stall=%0b expected 0/0", tag, evq.size(), cpuStall));
    for (int i = 0; i < 4; i++) pend[i] = 0;
  endtask

  task automatic rd_chk(int ch, int sub, int unsigned exp, string tag);
    @(negedge clk);
    regAddr = 6'(ch * 12 + sub);
    #1;
    chk(regRdata == 16'(exp), $sformatf("%s ch%0d+%0d read %h expected %h", tag, ch, sub, regRdata, 16'(exp)));
  endtask

  task automatic rd_model(int ch, string tag);
    for (int s = 0; s <= 10; s += 2) rd_chk(ch, s, mread(ch, s), tag);
  endtask

  // memory responder: ack and data one cycle after each read request
  bit rdPend = 0; logic [31:0] rdAddr = '0;
  always @(negedge clk) begin
    memAck = rdPend;
    memRdata = memf(rdAddr);
    rdPend = memRd;
    rdAddr = memAddr;
  end

  // every-clock comparison against the expected bus and interrupt stream
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memRd) begin
        if (evq.size() == 0 || evq[0].kind != 0)
          chk(0, $sformatf("R6 unexpected read at %h, expected none", memAddr));
        else begin
          chk(memAddr == evq[0].addr && memWord == evq[0].word,
              $sformatf("R6/R7/R11 read addr %h size %0b expected %h size %0b",
                        memAddr, memWord, evq[0].addr, evq[0].word));
          void'(evq.pop_front());
        end
      end
      if (memWr) begin
        if (evq.size() == 0 || evq[0].kind != 1)
          chk(0, $sformatf("R6 unexpected write at %h, expected none", memAddr));
        else begin
          chk(memAddr == evq[0].addr && memWdata == evq[0].data && memWord == evq[0].word
              && srcAdjErr == evq[0].err,
              $sformatf("R6/R7/R8 write addr %h data %h err %0b expected %h %h %0b",
                        memAddr, memWdata, srcAdjErr, evq[0].addr, evq[0].data, evq[0].err));
          void'(evq.pop_front());
        end
      end else if (srcAdjErr) chk(0, "R8 srcAdjErr outside a write, got 1 expected 0");
      if (irq != 0) begin
        if (evq.size() == 0 || evq[0].kind != 2)
          chk(0, $sformatf("R9 unexpected irq %b, expected 0000", irq));
        else begin
          chk(int'(irq) == evq[0].mask, $sformatf("R9 irq %b expected %b", irq, 4'(evq[0].mask)));
          void'(evq.pop_front());
        end
      end
      if ((memRd || memWr) && !cpuStall) chk(0, "R11 bus active with cpuStall 0, expected 1");
    end
  end

  task automatic summary();
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired, run did not complete");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mSrc[i] = 0; mDst[i] = 0; mWc[i] = 0; mCtl[i] = 0; pend[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int ch = 0; ch < 4; ch++) rd_model(ch, "R1");
    chk(!cpuStall && irq == 0 && !memRd && !memWr, "R1 idle outputs after reset, expected all 0");

    // R2 half writes
    reg_wr(2, 2, 16'hABCD); reg_wr(2, 0, 16'h1234);
    rd_chk(2, 2, 16'hABCD, "R2"); rd_chk(2, 0, 16'h1234, "R2");
    reg_wr(2, 0, 16'h5678); rd_chk(2, 2, 16'hABCD, "R2 hi kept");
    reg_wr(0, 6, 16'h0300); reg_wr(0, 4, 16'h0044); rd_chk(0, 6, 16'h0300, "R2 dst hi");
    reg_wr(3, 8, 16'h0007); rd_chk(3, 8, 16'h0007, "R2 count");

    // R4 R6 R7: halfword copy, both increment, interrupt at end
    setup(0, 32'h0000_1000, 32'h0200_0000, 4);
    reg_wr(0, 10, 16'hC000);
    wait_idle("R4");
    rd_chk(0, 0, 16'h1008, "R7 src inc"); rd_chk(0, 4, 16'h0008, "R7 dst inc");
    rd_chk(0, 10, 16'h4000, "R10 enable cleared");

    // R3 R7: word copy, source decrement, destination fixed
    setup(3, 32'h3000_0100, 32'h0400_00A0, 3);
    reg_wr(3, 10, 16'h84C0);
    wait_idle("R3");
    rd_chk(3, 0, 16'h00F4, "R7 src dec"); rd_chk(3, 4, 16'h00A0, "R7 dst fixed");

    // R8 illegal source code
    setup(1, 32'h0000_0700, 32'h0000_0900, 2);
    reg_wr(1, 10, 16'h8180);
    wait_idle("R8");
    rd_chk(1, 0, 16'h0700, "R8 src unchanged");

    // R6 zero count: only the interrupt
    setup(2, 32'h0000_0010, 32'h0000_0020, 0);
    reg_wr(2, 10, 16'hC000);
    wait_idle("R6 zero");
    rd_model(2, "R6 zero");

    // R4 R5: blank timings, ascending order on one pulse
    setup(2, 32'h0000_2200, 32'h0000_2400, 2);
    setup(0, 32'h0000_2000, 32'h0000_2100, 2);
    setup(1, 32'h0000_2600, 32'h0000_2800, 1);
    reg_wr(2, 10, 16'hD000); reg_wr(0, 10, 16'hD000); reg_wr(1, 10, 16'hE000);
    repeat (10) @(negedge clk);
    chk(!cpuStall, "R4 timing 1/2 write started nothing, cpuStall expected 0");
    blank(1);
    wait_idle("R5 vblank");
    blank(0);
    wait_idle("R5 hblank");
    blank(1);
    wait_idle("R5 disabled");
    for (int ch = 0; ch < 3; ch++) rd_model(ch, "R5");

    // R10 repeat with destination reload
    setup(1, 32'h0000_0500, 32'h0000_0800, 2);
    reg_wr(1, 10, 16'hE260);
    blank(0);
    wait_idle("R10");
    rd_chk(1, 4, 16'h0800, "R10 dst reloaded"); rd_chk(1, 10, 16'hE260, "R10 still enabled");
    rd_chk(1, 0, 16'h0504, "R10 src advanced");
    blank(0);
    wait_idle("R10 again");
    rd_model(1, "R10 again");

    // R12 second trigger while pending
    setup(0, 32'h0000_4000, 32'h0000_5000, 6);
    reg_wr(0, 10, 16'h9200);
    blank(1);
    blank(1);
    wait_idle("R12");
    rd_model(0, "R12");
    reg_wr(0, 10, 16'h0000);

    // R11 FIFO order of back-to-back immediate starts
    setup(3, 32'h0000_6000, 32'h0000_6100, 2);
    setup(1, 32'h0000_7000, 32'h0000_7100, 2);
    reg_wr(3, 10, 16'hC000);
    reg_wr(1, 10, 16'hC400);
    chk(cpuStall, "R11 cpuStall during queued work, got 0 expected 1");
    wait_idle("R11");
    blank(0);
    wait_idle("R5 no timing-2 channel");
    rd_model(1, "R11"); rd_model(3, "R11");
    summary();
  end
endmodule